// File: doc/BRIEF.md
# Counter-Rotating Ring Stop with Bounce-on-Full Ejection

This block is one node on two single-lane rings. One ring moves messages clockwise and the other moves them counter-clockwise. Each ring carries at most one message per cycle through each stop. Every message holds a destination node number and a payload. A message advances one stop per cycle and is never held. The stop does four things:

- It passes on traffic meant for other nodes.
- It takes traffic addressed to itself into a small local receive queue.
- It puts local requests onto whichever ring reaches the target in fewer hops.
- It signals a bounce when a message cannot be taken because the queue is full. The message then stays on its ring and returns on a later lap. The neighbours never see backpressure.

A local source offers messages through a valid/ready port. A local sink drains the receive queue through its own valid/ready port. Two single-cycle pulse outputs, one per ring, report each message that bounces at this stop.

Top module: `ringstop`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both ring outputs are invalid, the eject port shows no data and neither bounce pulse is high.
- R2: A valid incoming message whose destination differs from NODE_ID appears on the same ring's output one cycle later, with its destination and payload unchanged.
- R3: A valid incoming message whose destination equals NODE_ID is written to the receive queue when the queue has a free entry. The next cycle leaves that ring's output slot empty and makes the message visible at the eject port once the older entries have left.
- R4: A message for this node that finds no free entry appears one cycle later on the same ring's output, unchanged. In that same cycle, that ring's bounce output is high for exactly one cycle. Free entries are counted as DEPTH minus the occupancy at the start of the cycle; a pop in the same cycle is not counted as freeing an entry.
- R5: The local source may only use an output slot that is empty. injReady is low whenever the chosen ring's incoming slot holds a message that is not taken here, either a passing message or a bounced one. A message on the other ring does not affect injReady.
- R6: The ring for a local message is chosen from the hop count h = (injDest - NODE_ID) mod NODES. The clockwise ring is used when h <= NODES - h, which includes ties; otherwise the counter-clockwise ring is used. The injected message appears on the chosen ring's output one cycle after the handshake.
- R7: When both rings deliver a message for this node in one cycle and only one entry is free, the clockwise message is taken and the counter-clockwise message bounces.
- R8: The eject port returns messages in the order they were taken. Within a single cycle, the clockwise message is taken before the counter-clockwise one.
- R9: A slot emptied by ejection in a cycle can carry a local injection in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cwInValid | input | 1 | Clockwise ring input slot occupied |
| cwInDest | input | IDW | Clockwise input destination node |
| cwInData | input | DW | Clockwise input payload |
| ccwInValid | input | 1 | Counter-clockwise ring input slot occupied |
| ccwInDest | input | IDW | Counter-clockwise input destination node |
| ccwInData | input | DW | Counter-clockwise input payload |
| cwOutValid | output | 1 | Clockwise ring output slot occupied |
| cwOutDest | output | IDW | Clockwise output destination node |
| cwOutData | output | DW | Clockwise output payload |
| ccwOutValid | output | 1 | Counter-clockwise ring output slot occupied |
| ccwOutDest | output | IDW | Counter-clockwise output destination node |
| ccwOutData | output | DW | Counter-clockwise output payload |
| injValid | input | 1 | Local source offers a message |
| injDest | input | IDW | Destination of the offered message |
| injData | input | DW | Payload of the offered message |
| injReady | output | 1 | Offered message is accepted this cycle |
| ejValid | output | 1 | Receive queue has a message for the sink |
| ejData | output | DW | Payload at the head of the receive queue |
| ejReady | input | 1 | Sink takes the head message |
| bounceCw | output | 1 | One-cycle pulse: a clockwise message bounced here |
| bounceCcw | output | 1 | One-cycle pulse: a counter-clockwise message bounced here |

## Verification
The assertions rely on two conditions at the inputs. A local message is never addressed to this node. Every destination number lies below NODES. Under these conditions, a message for another node reaches the stop only on a ring input, never through the local port.

The stimulus keeps to these conditions. Local injections only target other nodes, and every ring message uses a node number between 0 and 7. Bounces are produced by holding the sink not-ready, which lets the queue fill before messages for this node arrive.

// File: rtl/ringstop_pkg.sv
package ringstop_pkg;

  // Per-cycle decisions from the control to the datapath.
  typedef struct packed {
    logic ejCw;    // clockwise arrival written to receive queue
    logic ejCcw;   // counter-clockwise arrival written to receive queue
    logic injCw;   // local message placed on clockwise ring
    logic injCcw;  // local message placed on counter-clockwise ring
    logic bncCw;   // clockwise arrival for this node left on ring
    logic bncCcw;  // counter-clockwise arrival for this node left on ring
  } stopStrobe_t;

endpackage

// File: rtl/ringstop_ejfifo.sv
module ringstop_ejfifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pushA,
  input  logic [DW-1:0]   dataA,
  input  logic            pushB,
  input  logic [DW-1:0]   dataB,
  input  logic            popReady,
  output logic            headValid,
  output logic [DW-1:0]   headData,
  output logic [CNTW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr, wrPtrNext1;
  logic          popEn;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wrPtrNext1 = bump(wrPtr);
  assign headValid  = (count != '0);
  assign headData   = mem[rdPtr];
  assign popEn      = headValid && popReady;

  // Second write lands one entry behind the first (cw first, then ccw).
  always_ff @(posedge clk) begin
    if (pushA) mem[wrPtr]      <= dataA;
    if (pushB) mem[wrPtrNext1] <= dataB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushB)      wrPtr <= bump(wrPtrNext1);
      else if (pushA) wrPtr <= wrPtrNext1;
      if (popEn)      rdPtr <= bump(rdPtr);
      count <= count + CNTW'(pushA) + CNTW'(pushB) - CNTW'(popEn);
    end
  end

  // R3: the queue never holds more than DEPTH entries
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH));

  // R8: a second write in one cycle always follows a first one
  a_r8_push_order: assert property (@(posedge clk) disable iff (!rstN)
    pushB |-> pushA);

endmodule

// File: rtl/ringstop_ctrl.sv
module ringstop_ctrl
  import ringstop_pkg::*;
#(
  parameter int NODES   = 8,
  parameter int NODE_ID = 0,
  parameter int DEPTH   = 4,
  parameter int IDW     = $clog2(NODES),
  parameter int CNTW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cwInValid,
  input  logic [IDW-1:0]  cwInDest,
  input  logic            ccwInValid,
  input  logic [IDW-1:0]  ccwInDest,
  input  logic            injValid,
  input  logic [IDW-1:0]  injDest,
  input  logic [CNTW-1:0] fifoCount,
  output stopStrobe_t     strb,
  output logic            injReady
);
  localparam logic [IDW-1:0] SELF = IDW'(NODE_ID);

  logic            cwMine, ccwMine;
  logic [CNTW-1:0] freeSlots;
  logic            cwSlotFree, ccwSlotFree;
  logic [IDW:0]    rawDiff, cwHop;
  logic            useCw;

  assign cwMine    = cwInValid  && (cwInDest  == SELF);
  assign ccwMine   = ccwInValid && (ccwInDest == SELF);
  assign freeSlots = CNTW'(DEPTH) - fifoCount;

  // Hop distance on the clockwise ring, then pick the shorter way.
  assign rawDiff = {1'b0, injDest} - (IDW + 1)'(NODE_ID);
  assign cwHop   = rawDiff[IDW] ? rawDiff + (IDW + 1)'(NODES) : rawDiff;
  assign useCw   = ({cwHop, 1'b0} <= (IDW + 2)'(NODES));

  always_comb begin
    strb        = '0;
    strb.ejCw   = cwMine && (freeSlots != '0);
    strb.ejCcw  = ccwMine && (freeSlots > CNTW'(strb.ejCw));
    strb.bncCw  = cwMine && !strb.ejCw;
    strb.bncCcw = ccwMine && !strb.ejCcw;
    cwSlotFree  = !cwInValid || strb.ejCw;
    ccwSlotFree = !ccwInValid || strb.ejCcw;
    injReady    = useCw ? cwSlotFree : ccwSlotFree;
    strb.injCw  = injValid && injReady && useCw;
    strb.injCcw = injValid && injReady && !useCw;
  end

  // R5: a slot holding another node's message is never taken by injection
  a_r5_cw_passing_wins: assert property (@(posedge clk) disable iff (!rstN)
    (cwInValid && cwInDest != SELF) |-> !strb.injCw);
  a_r5_ccw_passing_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ccwInValid && ccwInDest != SELF) |-> !strb.injCcw);

  // R7: the counter-clockwise arrival is never taken ahead of a waiting clockwise one
  a_r7_cw_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ejCcw && cwMine) |-> strb.ejCw);

  // R6: at most one ring is chosen for a local message
  a_r6_one_ring: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.injCw && strb.injCcw));

endmodule

// File: rtl/ringstop_dp.sv
module ringstop_dp
  import ringstop_pkg::*;
#(
  parameter int NODES   = 8,
  parameter int NODE_ID = 0,
  parameter int DEPTH   = 4,
  parameter int DW      = 16,
  parameter int IDW     = $clog2(NODES),
  parameter int CNTW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  stopStrobe_t     strb,
  input  logic            cwInValid,
  input  logic [IDW-1:0]  cwInDest,
  input  logic [DW-1:0]   cwInData,
  input  logic            ccwInValid,
  input  logic [IDW-1:0]  ccwInDest,
  input  logic [DW-1:0]   ccwInData,
  input  logic [IDW-1:0]  injDest,
  input  logic [DW-1:0]   injData,
  output logic            cwOutValid,
  output logic [IDW-1:0]  cwOutDest,
  output logic [DW-1:0]   cwOutData,
  output logic            ccwOutValid,
  output logic [IDW-1:0]  ccwOutDest,
  output logic [DW-1:0]   ccwOutData,
  output logic            bounceCw,
  output logic            bounceCcw,
  input  logic            ejReady,
  output logic            ejValid,
  output logic [DW-1:0]   ejData,
  output logic [CNTW-1:0] fifoCount
);
  localparam logic [IDW-1:0] SELF = IDW'(NODE_ID);

  logic          pushA, pushB;
  logic [DW-1:0] dataA;

  assign pushA = strb.ejCw || strb.ejCcw;
  assign pushB = strb.ejCw && strb.ejCcw;
  assign dataA = strb.ejCw ? cwInData : ccwInData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwOutValid  <= 1'b0;
      ccwOutValid <= 1'b0;
      bounceCw    <= 1'b0;
      bounceCcw   <= 1'b0;
    end else begin
      cwOutValid  <= strb.injCw  || (cwInValid  && !strb.ejCw);
      ccwOutValid <= strb.injCcw || (ccwInValid && !strb.ejCcw);
      bounceCw    <= strb.bncCw;
      bounceCcw   <= strb.bncCcw;
    end
  end

  always_ff @(posedge clk) begin
    cwOutDest  <= strb.injCw  ? injDest : cwInDest;
    cwOutData  <= strb.injCw  ? injData : cwInData;
    ccwOutDest <= strb.injCcw ? injDest : ccwInDest;
    ccwOutData <= strb.injCcw ? injData : ccwInData;
  end

  ringstop_ejfifo #(.DEPTH(DEPTH), .DW(DW), .CNTW(CNTW)) u_ejfifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushA    (pushA),
    .dataA    (dataA),
    .pushB    (pushB),
    .dataB    (ccwInData),
    .popReady (ejReady),
    .headValid(ejValid),
    .headData (ejData),
    .count    (fifoCount)
  );

  // R2: traffic for other nodes moves one stop per cycle, untouched
  a_r2_cw_forward: assert property (@(posedge clk) disable iff (!rstN)
    (cwInValid && cwInDest != SELF) |=>
      (cwOutValid && cwOutDest == $past(cwInDest) && cwOutData == $past(cwInData)));
  a_r2_ccw_forward: assert property (@(posedge clk) disable iff (!rstN)
    (ccwInValid && ccwInDest != SELF) |=>
      (ccwOutValid && ccwOutDest == $past(ccwInDest) && ccwOutData == $past(ccwInData)));

  // R4: a bounce pulse always accompanies a message for this node going round again
  a_r4_cw_bounce_on_ring: assert property (@(posedge clk) disable iff (!rstN)
    bounceCw |-> (cwOutValid && cwOutDest == SELF));
  a_r4_ccw_bounce_on_ring: assert property (@(posedge clk) disable iff (!rstN)
    bounceCcw |-> (ccwOutValid && ccwOutDest == SELF));

endmodule

// File: rtl/ringstop.sv
module ringstop
  import ringstop_pkg::*;
#(
  parameter int NODES   = 8,
  parameter int NODE_ID = 3,
  parameter int DEPTH   = 4,
  parameter int DW      = 16,
  parameter int IDW     = $clog2(NODES)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cwInValid,
  input  logic [IDW-1:0] cwInDest,
  input  logic [DW-1:0]  cwInData,
  input  logic           ccwInValid,
  input  logic [IDW-1:0] ccwInDest,
  input  logic [DW-1:0]  ccwInData,
  output logic           cwOutValid,
  output logic [IDW-1:0] cwOutDest,
  output logic [DW-1:0]  cwOutData,
  output logic           ccwOutValid,
  output logic [IDW-1:0] ccwOutDest,
  output logic [DW-1:0]  ccwOutData,
  input  logic           injValid,
  input  logic [IDW-1:0] injDest,
  input  logic [DW-1:0]  injData,
  output logic           injReady,
  output logic           ejValid,
  output logic [DW-1:0]  ejData,
  input  logic           ejReady,
  output logic           bounceCw,
  output logic           bounceCcw
);
  localparam int CNTW = $clog2(DEPTH + 1);

  stopStrobe_t     strb;
  logic [CNTW-1:0] fifoCount;

  ringstop_ctrl #(
    .NODES(NODES), .NODE_ID(NODE_ID), .DEPTH(DEPTH), .IDW(IDW), .CNTW(CNTW)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cwInValid (cwInValid),
    .cwInDest  (cwInDest),
    .ccwInValid(ccwInValid),
    .ccwInDest (ccwInDest),
    .injValid  (injValid),
    .injDest   (injDest),
    .fifoCount (fifoCount),
    .strb      (strb),
    .injReady  (injReady)
  );

  ringstop_dp #(
    .NODES(NODES), .NODE_ID(NODE_ID), .DEPTH(DEPTH), .DW(DW), .IDW(IDW), .CNTW(CNTW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cwInValid  (cwInValid),
    .cwInDest   (cwInDest),
    .cwInData   (cwInData),
    .ccwInValid (ccwInValid),
    .ccwInDest  (ccwInDest),
    .ccwInData  (ccwInData),
    .injDest    (injDest),
    .injData    (injData),
    .cwOutValid (cwOutValid),
    .cwOutDest  (cwOutDest),
    .cwOutData  (cwOutData),
    .ccwOutValid(ccwOutValid),
    .ccwOutDest (ccwOutDest),
    .ccwOutData (ccwOutData),
    .bounceCw   (bounceCw),
    .bounceCcw  (bounceCcw),
    .ejReady    (ejReady),
    .ejValid    (ejValid),
    .ejData     (ejData),
    .fifoCount  (fifoCount)
  );

endmodule

// File: tb/ringstop_tb.sv
module ringstop_tb;
  localparam int NODES = 8, NODE_ID = 3, DEPTH = 4, DW = 16, IDW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cwInValid = 0, ccwInValid = 0, injValid = 0, ejReady = 0;
  logic [IDW-1:0] cwInDest = '0, ccwInDest = '0, injDest = '0;
  logic [DW-1:0]  cwInData = '0, ccwInData = '0, injData = '0;
  logic cwOutValid, ccwOutValid, injReady, ejValid, bounceCw, bounceCcw;
  logic [IDW-1:0] cwOutDest, ccwOutDest;
  logic [DW-1:0]  cwOutData, ccwOutData, ejData;

  int total = 0, bad = 0;
  logic [DW-1:0] expQ[$];

  always #10 clk = ~clk;

  ringstop #(.NODES(NODES), .NODE_ID(NODE_ID), .DEPTH(DEPTH), .DW(DW), .IDW(IDW)) u_dut (
    .clk(clk), .rstN(rstN),
    .cwInValid(cwInValid), .cwInDest(cwInDest), .cwInData(cwInData),
    .ccwInValid(ccwInValid), .ccwInDest(ccwInDest), .ccwInData(ccwInData),
    .cwOutValid(cwOutValid), .cwOutDest(cwOutDest), .cwOutData(cwOutData),
    .ccwOutValid(ccwOutValid), .ccwOutDest(ccwOutDest), .ccwOutData(ccwOutData),
    .injValid(injValid), .injDest(injDest), .injData(injData), .injReady(injReady),
    .ejValid(ejValid), .ejData(ejData), .ejReady(ejReady),
    .bounceCw(bounceCw), .bounceCcw(bounceCcw)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    cwInValid = 0; ccwInValid = 0; injValid = 0;
  endtask

  task automatic sendCw(input logic [IDW-1:0] d, input logic [DW-1:0] v);
    cwInValid = 1; cwInDest = d; cwInData = v;
  endtask

  task automatic sendCcw(input logic [IDW-1:0] d, input logic [DW-1:0] v);
    ccwInValid = 1; ccwInDest = d; ccwInData = v;
  endtask

  task automatic offer(input logic [IDW-1:0] d, input logic [DW-1:0] v);
    injValid = 1; injDest = d; injData = v;
  endtask

  // Scoreboard monitor: handshake seen at the falling edge completes at the next rising edge.
  always @(negedge clk) begin
    if (rstN && ejValid && ejReady) begin
      if (expQ.size() == 0) chk("R8 unexpected eject", 32'(ejData), 32'hFFFF_FFFF);
      else chk("R8 eject order", 32'(ejData), 32'(expQ.pop_front()));
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 cwOutValid in reset", 32'(cwOutValid), 0);
    chk("R1 ccwOutValid in reset", 32'(ccwOutValid), 0);
    chk("R1 ejValid in reset", 32'(ejValid), 0);
    chk("R1 bounce in reset", 32'({bounceCw, bounceCcw}), 0);
    rstN = 1;
    tick();
    chk("R1 outputs after reset", 32'({cwOutValid, ccwOutValid, ejValid, bounceCw, bounceCcw}), 0);

    // R2 forwarding on both rings
    sendCw(5, 16'hA005); sendCcw(0, 16'hB000);
    tick();
    chk("R2 cw fwd", 32'({cwOutValid, cwOutDest, cwOutData}), 32'({1'b1, 3'd5, 16'hA005}));
    chk("R2 ccw fwd", 32'({ccwOutValid, ccwOutDest, ccwOutData}), 32'({1'b1, 3'd0, 16'hB000}));
    chk("R2 no bounce", 32'({bounceCw, bounceCcw}), 0);

    // R3 single eject, sink held off
    idle(); sendCw(3, 16'h1111); expQ.push_back(16'h1111);
    tick();
    chk("R3 slot emptied", 32'(cwOutValid), 0);
    chk("R3 ejValid", 32'(ejValid), 1);
    chk("R3 ejData", 32'(ejData), 32'h1111);

    // R8 two arrivals in one cycle, both taken, cw first
    idle(); sendCw(3, 16'h3333); sendCcw(3, 16'h2222);
    expQ.push_back(16'h3333); expQ.push_back(16'h2222);
    tick();
    chk("R8 both taken", 32'({cwOutValid, ccwOutValid, bounceCw, bounceCcw}), 0);

    // R7 one free entry: cw taken, ccw bounces
    idle(); sendCw(3, 16'h4444); sendCcw(3, 16'h5555); expQ.push_back(16'h4444);
    tick();
    chk("R7 cw taken", 32'(cwOutValid), 0);
    chk("R7 ccw bounced", 32'({ccwOutValid, ccwOutDest, ccwOutData}), 32'({1'b1, 3'd3, 16'h5555}));
    chk("R7 pulses", 32'({bounceCw, bounceCcw}), 32'b01);

    // R4 queue full
    idle(); sendCw(3, 16'h6666);
    tick();
    chk("R4 cw bounced", 32'({cwOutValid, cwOutDest, cwOutData}), 32'({1'b1, 3'd3, 16'h6666}));
    chk("R4 pulses", 32'({bounceCw, bounceCcw}), 32'b10);
    chk("R4 head unchanged", 32'(ejData), 32'h1111);
    idle();
    tick();
    chk("R4 single pulse", 32'({bounceCw, bounceCcw}), 0);

    // R5 bounced message keeps its slot against injection
    sendCw(3, 16'h6767); offer(5, 16'hC0DE);
    #1 chk("R5 ready low on bounce", 32'(injReady), 0);
    tick();
    chk("R5 bounced kept", 32'({cwOutValid, cwOutDest, cwOutData}), 32'({1'b1, 3'd3, 16'h6767}));

    // R6 direction choice
    idle(); offer(5, 16'hC005);
    #1 chk("R6 ready dest5", 32'(injReady), 1);
    tick();
    chk("R6 dest5 cw", 32'({cwOutValid, cwOutDest, cwOutData, ccwOutValid}), 32'({1'b1, 3'd5, 16'hC005, 1'b0}));
    idle(); offer(1, 16'hC001);
    tick();
    chk("R6 dest1 ccw", 32'({ccwOutValid, ccwOutDest, ccwOutData, cwOutValid}), 32'({1'b1, 3'd1, 16'hC001, 1'b0}));
    idle(); offer(7, 16'hC007);
    tick();
    chk("R6 tie cw", 32'({cwOutValid, cwOutDest, cwOutData, ccwOutValid}), 32'({1'b1, 3'd7, 16'hC007, 1'b0}));

    // R5 passing message wins the slot
    idle(); sendCw(6, 16'hD006); offer(5, 16'hC0DE);
    #1 chk("R5 ready low", 32'(injReady), 0);
    tick();
    chk("R5 passing kept", 32'({cwOutValid, cwOutDest, cwOutData}), 32'({1'b1, 3'd6, 16'hD006}));
    chk("R5 nothing on ccw", 32'(ccwOutValid), 0);

    // R5 traffic on the other ring does not block
    idle(); sendCcw(0, 16'hB100); offer(5, 16'hC105);
    #1 chk("R5 other ring ready", 32'(injReady), 1);
    tick();
    chk("R5 inject cw", 32'({cwOutValid, cwOutDest, cwOutData}), 32'({1'b1, 3'd5, 16'hC105}));
    chk("R5 ccw passes", 32'({ccwOutValid, ccwOutDest, ccwOutData}), 32'({1'b1, 3'd0, 16'hB100}));

    // Drain the queue, R8 order checked by monitor
    idle(); ejReady = 1;
    repeat (6) tick();
    chk("R8 queue drained", 32'(expQ.size()), 0);
    chk("R8 ejValid low", 32'(ejValid), 0);

    // R9 ejection frees slot for injection in same cycle
    sendCw(3, 16'h7777); expQ.push_back(16'h7777); offer(5, 16'hE005);
    #1 chk("R9 ready", 32'(injReady), 1);
    tick();
    chk("R9 injected", 32'({cwOutValid, cwOutDest, cwOutData}), 32'({1'b1, 3'd5, 16'hE005}));
    idle();
    repeat (3) tick();
    chk("R9 ejected", 32'(expQ.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule